// File: doc/BRIEF.md
# Dual Gated Timer/Counter

This block holds two independent timer/counter channels in the classic eight-bit microcontroller style. Each channel has a 16-bit count made of a low byte and a high byte. A channel counts in one of two ways: it counts internal ticks, which are the system clock divided by `PRESCALE`, or it counts falling edges on its own external event input. A gate bit, a run bit and an external gate level together decide whether a channel may advance. When a count wraps, the channel's overflow flag is set, and each flag drives an interrupt request output.

Software reaches everything through a byte-wide register bus with a three-bit address. Reads are combinational. Writes land on the next rising clock edge. Each channel's 4-bit setup field picks one of four counting layouts: 13-bit, 16-bit, 8-bit with auto-reload, and a split layout. In the split layout channel 0 becomes two 8-bit counters and channel 1 can be parked. An overflow flag is cleared either by a software write or by a one-cycle acknowledge pulse from the interrupt controller.

Top module: `dual_tc`

## Requirements
- R1: Register addresses: 0 is setup, 1 is control, 2 and 3 are channel 0 low and high, 4 and 5 are channel 1 low and high. Channel 1 uses setup bits 7:4 and channel 0 uses bits 3:0. Within a field, bit 3 is gate, bit 2 is event-count select, and bits 1:0 are the layout. Control bit 7 is flag 1, bit 6 is run 1, bit 5 is flag 0, bit 4 is run 0, and bits 3:0 read zero. After reset every register reads zero and `irq` is 0.
- R2: Layout 1 is a 16-bit count {high,low} that steps by one per qualified tick. On the step from FFFF to 0000 it sets the channel's flag.
- R3: Layout 0 is a 13-bit count formed from the high byte and low bits 4:0. Low bits 7:5 hold their value. The flag is set on the step from all ones to zero.
- R4: Layout 2 steps the low byte only. When the low byte is FF, the next step loads it from the high byte, which is left unchanged, and sets the flag.
- R5: When channel 0 uses layout 3, its low byte is an 8-bit counter under channel 0's run, gate, select and flag 0. Its high byte counts internal ticks under run 1 and sets flag 1 when it wraps. In this case the overflow of channel 1 does not set flag 1.
- R6: A channel 1 set to layout 3 holds both of its count bytes.
- R7: In timer mode (select 0), a running ungated channel advances exactly once every `PRESCALE` clock cycles.
- R8: In event mode (select 1), a channel advances exactly once for each falling edge of its `evt_in` bit. It does not count ticks. The input passes through a two-flop synchroniser, and the count changes on the third rising clock edge after the fall.
- R9: A channel advances only while its run bit is 1. With its gate bit set, it also needs its `gate_in` bit to be high.
- R10: A bus write to a count byte is visible after the next clock edge. In that same cycle it cancels the increment of the whole channel, including any overflow.
- R11: `irq` equals the two flags. A control write loads both flags from bits 7 and 5, and this write takes priority over everything else. A hardware overflow takes priority over an `irq_ack` pulse in the same cycle. Otherwise, `irq_ack` clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| evt_in | input | 2 | External event inputs, counted on falling edges |
| gate_in | input | 2 | Active-high external gate levels |
| irq_ack | input | 2 | Interrupt acknowledge pulses that clear the flags |
| irq | output | 2 | Overflow flags as interrupt requests |

## Verification
Two pairs of functions can collide in the same cycle. The first pair is a software write to a count byte and the increment of that channel. The bench writes the low byte while the channel runs at one tick per clock. It then checks that the written value appears unchanged right after the edge and steps by one on the following edge. The second pair is an overflow and an acknowledge pulse. The bench preloads FFFF, starts the channel and holds `irq_ack` high during the wrapping cycle, then expects the flag to be set after that edge.

// File: rtl/dual_tc.sv
module dual_tc #(
  parameter int PRESCALE = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [1:0] evt_in,
  input  logic [1:0] gate_in,
  input  logic [1:0] irq_ack,
  output logic [1:0] irq
);

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [7:0] mode_q;
  logic [1:0] run_q, ovf_q;
  logic [7:0] lo_q [2];
  logic [7:0] hi_q [2];
  logic [7:0] lo_n [2];
  logic [7:0] hi_n [2];
  logic [1:0] s1, s2, s3, fall, wrap, hw_set;
  logic       tick, split, hi0_wrap;
  logic       ctrl_wr;

  generate
    if (PRESCALE > 1) begin : g_pre
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else if (pre_q == PW'(PRESCALE - 1)) pre_q <= '0;
        else pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PW'(PRESCALE - 1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 2'b11;
      s2 <= 2'b11;
      s3 <= 2'b11;
    end else begin
      s1 <= evt_in;
      s2 <= s1;
      s3 <= s2;
    end
  end
  assign fall    = s3 & ~s2;
  assign split   = (mode_q[1:0] == 2'd3);
  assign ctrl_wr = bus_we && (bus_addr == A_CTRL);

  always_comb begin
    logic [3:0]  fld;
    logic        wr_lo, wr_hi, adv;
    logic [12:0] t13;
    hi0_wrap = 1'b0;
    wrap     = 2'b00;
    for (int c = 0; c < 2; c++) begin
      fld   = mode_q[4*c +: 4];
      wr_lo = bus_we && (bus_addr == 3'(2 + 2*c));
      wr_hi = bus_we && (bus_addr == 3'(3 + 2*c));
      adv   = run_q[c] && (!fld[3] || gate_in[c]) &&
              (fld[2] ? fall[c] : tick) && !(wr_lo || wr_hi);
      lo_n[c] = lo_q[c];
      hi_n[c] = hi_q[c];
      t13     = {hi_q[c], lo_q[c][4:0]} + 13'd1;
      if (adv) begin
        case (fld[1:0])
          2'd0: begin
            lo_n[c] = {lo_q[c][7:5], t13[4:0]};
            hi_n[c] = t13[12:5];
            wrap[c] = &{hi_q[c], lo_q[c][4:0]};
          end
          2'd1: begin
            {hi_n[c], lo_n[c]} = {hi_q[c], lo_q[c]} + 16'd1;
            wrap[c] = &{hi_q[c], lo_q[c]};
          end
          2'd2: begin
            if (&lo_q[c]) begin
              lo_n[c] = hi_q[c];
              wrap[c] = 1'b1;
            end else begin
              lo_n[c] = lo_q[c] + 8'd1;
            end
          end
          default: begin
            if (c == 0) begin
              lo_n[c] = lo_q[c] + 8'd1;
              wrap[c] = &lo_q[c];
            end
          end
        endcase
      end
      if (c == 0 && split && run_q[1] && tick && !(wr_lo || wr_hi)) begin
        hi_n[c]  = hi_q[c] + 8'd1;
        hi0_wrap = &hi_q[c];
      end
      if (wr_lo) lo_n[c] = bus_wdata;
      if (wr_hi) hi_n[c] = bus_wdata;
    end
  end

  assign hw_set[0] = wrap[0];
  assign hw_set[1] = split ? hi0_wrap : wrap[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      ovf_q  <= '0;
      for (int c = 0; c < 2; c++) begin
        lo_q[c] <= '0;
        hi_q[c] <= '0;
      end
    end else begin
      if (bus_we && bus_addr == A_MODE) mode_q <= bus_wdata;
      for (int c = 0; c < 2; c++) begin
        lo_q[c] <= lo_n[c];
        hi_q[c] <= hi_n[c];
        if (ctrl_wr) begin
          run_q[c] <= bus_wdata[4 + 2*c];
          ovf_q[c] <= bus_wdata[5 + 2*c];
        end else if (hw_set[c]) begin
          ovf_q[c] <= 1'b1;
        end else if (irq_ack[c]) begin
          ovf_q[c] <= 1'b0;
        end
      end
    end
  end

  assign irq = ovf_q;

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = mode_q;
      3'd1:    bus_rdata = {ovf_q[1], run_q[1], ovf_q[0], run_q[0], 4'b0000};
      3'd2:    bus_rdata = lo_q[0];
      3'd3:    bus_rdata = hi_q[0];
      3'd4:    bus_rdata = lo_q[1];
      3'd5:    bus_rdata = hi_q[1];
      default: bus_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/dual_tc_chk.sv
module dual_tc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [1:0] irq_ack,
  input logic [1:0] irq,
  input logic [7:0] mode_q,
  input logic [1:0] run_q,
  input logic [7:0] lo0,
  input logic [7:0] lo1,
  input logic [7:0] hi1
);

  logic wr_c0, wr_c1;
  assign wr_c0 = bus_we && (bus_addr == 3'd2 || bus_addr == 3'd3);
  assign wr_c1 = bus_we && (bus_addr == 3'd4 || bus_addr == 3'd5);

  p_ctrl_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 3'd1 |=> irq == {$past(bus_wdata[7]), $past(bus_wdata[5])});

  p_ack_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack[0] && irq[0] && !(bus_we && bus_addr == 3'd1) && lo0[4:0] != 5'h1F
    |=> !irq[0]);

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 3'd2 |=> lo0 == $past(bus_wdata));

  p_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q[0] && !wr_c0 |=> $stable(lo0));

  p_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[5:4] == 2'd3 && !wr_c1 |=> $stable(lo1) && $stable(hi1));

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1:0] == 2'd1 && !wr_c0 |=> (lo0 == $past(lo0)) || (lo0 == $past(lo0) + 8'd1));

endmodule

bind dual_tc dual_tc_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_ack   (irq_ack),
  .irq       (irq),
  .mode_q    (mode_q),
  .run_q     (run_q),
  .lo0       (lo_q[0]),
  .lo1       (lo_q[1]),
  .hi1       (hi_q[1])
);

// File: tb/dual_tc_test.sv
module dual_tc_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] mode, lo, hi, n, elo, ehi, eflag;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h01, 8'hFE, 8'hFF, 8'd4, 8'h02, 8'h00, 8'd1},
    '{8'h00, 8'hFE, 8'hFF, 8'd3, 8'hE1, 8'h00, 8'd1},
    '{8'h02, 8'hFE, 8'h80, 8'd4, 8'h82, 8'h80, 8'd1},
    '{8'h01, 8'h10, 8'h00, 8'd5, 8'h15, 8'h00, 8'd0},
    '{8'h00, 8'h1F, 8'h05, 8'd1, 8'h00, 8'h06, 8'd0},
    '{8'h02, 8'h00, 8'h33, 8'd2, 8'h02, 8'h33, 8'd0}
  };

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, rd_ps;
  logic [1:0] evt_in = 2'b11, gate_in = 0, irq_ack = 0, irq, irq_ps;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_tc #(.PRESCALE(1)) uut (
    .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .evt_in, .gate_in, .irq_ack, .irq);

  dual_tc #(.PRESCALE(4)) uut_ps (
    .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata(rd_ps),
    .evt_in, .gate_in, .irq_ack, .irq(irq_ps));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check($sformatf("R1 reset reg %0d", a), v, 0);
    end
    check("R1 reset irq", irq, 0);

    foreach (VECS[i]) begin
      wr(1, 8'h00);
      wr(0, VECS[i].mode);
      wr(2, VECS[i].lo);
      wr(3, VECS[i].hi);
      wr(1, 8'h10);
      repeat (int'(VECS[i].n) - 1) @(negedge clk);
      check($sformatf("R2/R3/R4 vec %0d flag", i), irq[0], int'(VECS[i].eflag));
      wr(1, 8'h00);
      rd(2, v); check($sformatf("R2/R3/R4 vec %0d low", i), v, VECS[i].elo);
      rd(3, v); check($sformatf("R2/R3/R4 vec %0d high", i), v, VECS[i].ehi);
    end

    // R8 event counting
    wr(0, 8'h05); wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h10);
    repeat (5) @(negedge clk);
    rd(2, v); check("R8 no tick counting", v, 0);
    for (int k = 0; k < 3; k++) begin
      evt_in[0] = 0; repeat (4) @(negedge clk);
      evt_in[0] = 1; repeat (4) @(negedge clk);
    end
    rd(2, v); check("R8 one per falling edge", v, 3);
    wr(1, 8'h00);

    // R9 gating and run
    wr(0, 8'h09); wr(2, 8'h00); wr(1, 8'h10);
    repeat (6) @(negedge clk);
    rd(2, v); check("R9 gate low holds", v, 0);
    gate_in[0] = 1; repeat (5) @(negedge clk); gate_in[0] = 0;
    rd(2, v); check("R9 gate high counts", v, 5);
    wr(1, 8'h00);
    gate_in[0] = 1; repeat (4) @(negedge clk); gate_in[0] = 0;
    rd(2, v); check("R9 run clear stops", v, 5);

    // R10 write versus increment
    wr(0, 8'h01); wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h10);
    repeat (3) @(negedge clk);
    wr(2, 8'h40);
    rd(2, v); check("R10 write wins", v, 8'h40);
    @(negedge clk);
    rd(2, v); check("R10 count resumes", v, 8'h41);
    wr(1, 8'h00);

    // R11 overflow versus acknowledge
    wr(2, 8'hFF); wr(3, 8'hFF); wr(1, 8'h10);
    irq_ack = 2'b01; @(negedge clk); irq_ack = 2'b00;
    check("R11 set beats ack", irq[0], 1);
    wr(1, 8'h00);
    wr(1, 8'hA0);
    rd(1, v); check("R1 ctrl readback", v, 8'hA0);
    check("R11 ctrl write sets flags", irq, 2'b11);
    irq_ack = 2'b01; @(negedge clk); irq_ack = 2'b00;
    check("R11 ack clears one flag", irq, 2'b10);
    wr(1, 8'h00);
    check("R11 software clear", irq, 2'b00);

    // R7 prescale
    wr(0, 8'h01); wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h10);
    repeat (39) @(negedge clk);
    wr(1, 8'h00);
    rd(2, v); check("R7 prescale 1", v, 40);
    bus_addr = 3'd2; #1 check("R7 prescale 4", rd_ps, 10);

    // R5 split layout
    wr(0, 8'h03); wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 8'h50);
    @(negedge clk);
    check("R5 high half sets flag 1", irq, 2'b10);
    @(negedge clk);
    check("R5 low half sets flag 0", irq, 2'b11);
    wr(1, 8'h00);
    rd(2, v); check("R5 low half count", v, 8'h01);
    rd(3, v); check("R5 high half count", v, 8'h02);

    // R6 channel 1 parked
    wr(0, 8'h10); wr(4, 8'h05); wr(5, 8'h00); wr(1, 8'h40);
    repeat (3) @(negedge clk);
    wr(1, 8'h00);
    rd(4, v); check("R2 channel 1 counts", v, 8'h09);
    wr(0, 8'h30); wr(1, 8'h40);
    repeat (5) @(negedge clk);
    wr(1, 8'h00);
    rd(4, v); check("R6 channel 1 parked", v, 8'h09);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1;
    $finish;
  end
endmodule